// File: doc/BRIEF.md
# Maskable Sticky Receiver Error Logger

This block sits behind a digital-audio receiver. It gathers the error events that the receiver reports once per subframe and keeps them in a status register. The events are parity, biphase, confidence, PLL unlock, validity, channel-status CRC and Q-subcode CRC. A mask register selects which events count. A mask bit of 1 lets its event through, and the mask is all zeros after reset, so every event is ignored until software enables it.

An enabled event does four things:
- it sets its sticky bit, which stays set until software reads the register;
- it emits a one-cycle receiver-error pulse;
- it keeps the interrupt request high;
- for the five sample-related errors only, it asks the sample-substitution stage to hold the previous sample or to zero the current one.

The two CRC errors are logged but never alter the audio sample. A read strobe returns the latched value one cycle later and clears the register in the same step, so a second read shows whether the condition is still present.

Top module: `rxerr_logger`

## Requirements
- R1: After synchronous reset, the sticky register, the mask, `rd_data`, `rerr_pulse`, `irq`, `sub_hold` and `sub_mute` are all zero.
- R2: An event is taken only when its mask bit is 1 and `sf_stb` is high. With the reset mask of 0, no event is ever logged.
- R3: An enabled event sets its sticky bit at the next clock edge. The bit then stays set, whatever events follow, until a read clears it.
- R4: A cycle with `rd_stb` high puts the sticky register (bit 7 reads 0) on `rd_data` at the next edge and clears every sticky bit. `rd_data` keeps its value until the next read.
- R5: An enabled event that arrives in the same cycle as a read is not lost. That read returns the old value, and the new bit remains set afterwards.
- R6: `rerr_pulse` is high for exactly the one cycle after an `sf_stb` cycle that carries at least one enabled event, and is low otherwise.
- R7: `irq` is a level signal. It is high in a cycle exactly when, one cycle earlier, some sticky bit was set while its mask bit was 1.
- R8: The `hold_mode` encoding is 2'b00 hold, 2'b01 zero, 2'b10 or 2'b11 pass. On an `sf_stb` cycle with an enabled sample-related event, the next edge sets `sub_hold` in hold mode and `sub_mute` in zero mode. In pass mode neither is set. On an `sf_stb` cycle without such an event, both are cleared.
- R9: The CRC events at bit 5 (channel status) and bit 6 (Q subcode) never set `sub_hold` or `sub_mute`, even when they are enabled.
- R10: `sub_hold` and `sub_mute` change only at the edge that follows an `sf_stb` cycle.
- R11: The bit order, LSB first, is: 0 parity, 1 biphase, 2 confidence, 3 validity, 4 PLL unlock, 5 channel-status CRC, 6 Q-subcode CRC. Bit 7 is unused and reads 0. `evt`, the mask and `rd_data` all use this order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_stb | input | 1 | Subframe boundary; `evt` is valid in this cycle |
| evt | input | 7 | Error events for the closing subframe, bit order per R11 |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 7 | New mask value, 1 = enabled |
| rd_stb | input | 1 | Read-and-clear strobe for the error register |
| hold_mode | input | 2 | Sample substitution mode per R8 |
| rd_data | output | 8 | Value returned by the last read |
| rerr_pulse | output | 1 | One-cycle receiver-error pulse |
| irq | output | 1 | Level interrupt request |
| sub_hold | output | 1 | Request to repeat the previous sample |
| sub_mute | output | 1 | Request to replace the sample with zero |

## Verification
Single enabled events on distinct bits show that the bit order holds and that each bit stays latched until the read that clears it. Reads with and without a simultaneous event separate the clearing of old bits from the loss of a new one. CRC-only events, compared with sample-related events under each hold mode, show that logging is kept apart from sample substitution. Idle cycles without `sf_stb` show that the substitution outputs only move on boundaries. A long random run, with mask writes, boundaries, reads and modes all mixed, is compared every cycle against a behavioural model.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;
  localparam int ERR_N = 7;

  localparam int B_PARITY = 0;
  localparam int B_BIPHASE = 1;
  localparam int B_CONF = 2;
  localparam int B_VALID = 3;
  localparam int B_UNLOCK = 4;
  localparam int B_CSCRC = 5;
  localparam int B_QCRC = 6;

  typedef enum logic [1:0] {
    HM_HOLD = 2'b00,
    HM_ZERO = 2'b01,
    HM_PASS = 2'b10
  } hold_mode_e;
endpackage

// File: rtl/rxerr_gate.sv
module rxerr_gate #(
  parameter int ERR_W = rxerr_pkg::ERR_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mask_wr,
  input  logic [ERR_W-1:0] mask_wdata,
  input  logic             sf_stb,
  input  logic [ERR_W-1:0] evt,
  output logic [ERR_W-1:0] mask_q,
  output logic [ERR_W-1:0] hit
);
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  // enabled events of the closing subframe
  always_comb hit = sf_stb ? (evt & mask_q) : '0;
endmodule

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
  parameter int ERR_W = rxerr_pkg::ERR_N,
  localparam int REG_W = ERR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] hit,
  input  logic             rd_stb,
  output logic [ERR_W-1:0] sticky_q,
  output logic [REG_W-1:0] rd_q
);
  // one cell per error bit; a new hit outranks the clear
  for (genvar i = 0; i < ERR_W; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) sticky_q[i] <= 1'b0;
      else if (hit[i]) sticky_q[i] <= 1'b1;
      else if (rd_stb) sticky_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_stb) rd_q <= {1'b0, sticky_q};
  end
endmodule

// File: rtl/rxerr_drive.sv
module rxerr_drive #(
  parameter int ERR_W = rxerr_pkg::ERR_N,
  parameter logic [ERR_W-1:0] AFFECT = 'h1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_stb,
  input  logic [ERR_W-1:0] hit,
  input  logic [ERR_W-1:0] sticky_q,
  input  logic [ERR_W-1:0] mask_q,
  input  logic [1:0]       hold_mode,
  output logic             rerr_pulse,
  output logic             irq,
  output logic             sub_hold,
  output logic             sub_mute
);
  import rxerr_pkg::*;

  logic sample_err;
  always_comb sample_err = |(hit & AFFECT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rerr_pulse <= 1'b0;
      irq <= 1'b0;
      sub_hold <= 1'b0;
      sub_mute <= 1'b0;
    end else begin
      rerr_pulse <= |hit;
      irq <= |(sticky_q & mask_q);
      if (sf_stb) begin
        sub_hold <= sample_err && (hold_mode == HM_HOLD);
        sub_mute <= sample_err && (hold_mode == HM_ZERO);
      end
    end
  end
endmodule

// File: rtl/rxerr_logger.sv
module rxerr_logger #(
  parameter int ERR_W = rxerr_pkg::ERR_N,
  parameter logic [ERR_W-1:0] AFFECT = 'h1F,
  localparam int REG_W = ERR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_stb,
  input  logic [ERR_W-1:0] evt,
  input  logic             mask_wr,
  input  logic [ERR_W-1:0] mask_wdata,
  input  logic             rd_stb,
  input  logic [1:0]       hold_mode,
  output logic [REG_W-1:0] rd_data,
  output logic             rerr_pulse,
  output logic             irq,
  output logic             sub_hold,
  output logic             sub_mute
);
  logic [ERR_W-1:0] mask_q;
  logic [ERR_W-1:0] hit;
  logic [ERR_W-1:0] sticky_q;

  rxerr_gate #(.ERR_W(ERR_W)) u_gate (
    .clk(clk), .rst(rst), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .sf_stb(sf_stb), .evt(evt), .mask_q(mask_q), .hit(hit)
  );

  rxerr_sticky #(.ERR_W(ERR_W)) u_sticky (
    .clk(clk), .rst(rst), .hit(hit), .rd_stb(rd_stb),
    .sticky_q(sticky_q), .rd_q(rd_data)
  );

  rxerr_drive #(.ERR_W(ERR_W), .AFFECT(AFFECT)) u_drive (
    .clk(clk), .rst(rst), .sf_stb(sf_stb), .hit(hit), .sticky_q(sticky_q),
    .mask_q(mask_q), .hold_mode(hold_mode), .rerr_pulse(rerr_pulse),
    .irq(irq), .sub_hold(sub_hold), .sub_mute(sub_mute)
  );
endmodule

// File: rtl/rxerr_logger_chk.sv
module rxerr_logger_chk #(
  parameter int ERR_W = rxerr_pkg::ERR_N,
  parameter logic [ERR_W-1:0] AFFECT = 'h1F
) (
  input logic             clk,
  input logic             rst,
  input logic             sf_stb,
  input logic             rd_stb,
  input logic [ERR_W-1:0] evt,
  input logic [ERR_W-1:0] mask_q,
  input logic [ERR_W-1:0] sticky_q,
  input logic             rerr_pulse,
  input logic             irq,
  input logic             sub_hold,
  input logic             sub_mute
);
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R3
  AST_SET_SURVIVES_READ: assert property (@(posedge clk) disable iff (rst)
    (sf_stb && rd_stb && ((evt & mask_q) != '0)) |=> (sticky_q != '0)); // R5
  AST_NO_PULSE_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!sf_stb || ((evt & mask_q) == '0)) |=> !rerr_pulse); // R6
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (sticky_q == '0) |=> !irq); // R7
  AST_SUB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sub_hold && sub_mute)); // R8
  AST_CRC_NO_SUB: assert property (@(posedge clk) disable iff (rst)
    (sf_stb && ((evt & mask_q & AFFECT) == '0)) |=> (!sub_hold && !sub_mute)); // R9
  AST_SUB_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !sf_stb |=> ($stable(sub_hold) && $stable(sub_mute))); // R10
endmodule

bind rxerr_logger rxerr_logger_chk #(.ERR_W(ERR_W), .AFFECT(AFFECT)) u_chk (
  .clk(clk), .rst(rst), .sf_stb(sf_stb), .rd_stb(rd_stb), .evt(evt),
  .mask_q(mask_q), .sticky_q(sticky_q), .rerr_pulse(rerr_pulse), .irq(irq),
  .sub_hold(sub_hold), .sub_mute(sub_mute)
);

// File: tb/rxerr_logger_tb.sv
module rxerr_logger_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sf_stb = 1'b0, mask_wr = 1'b0, rd_stb = 1'b0;
  logic [6:0] evt = '0, mask_wdata = '0;
  logic [1:0] hold_mode = 2'b00;
  logic [7:0] rd_data;
  logic rerr_pulse, irq, sub_hold, sub_mute;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxerr_logger u_dut (
    .clk(clk), .rst(rst), .sf_stb(sf_stb), .evt(evt), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .rd_stb(rd_stb), .hold_mode(hold_mode),
    .rd_data(rd_data), .rerr_pulse(rerr_pulse), .irq(irq),
    .sub_hold(sub_hold), .sub_mute(sub_mute)
  );

  // behavioural reference model
  logic [6:0] m_mask = '0, m_sticky = '0;
  logic [7:0] m_rd = '0;
  logic m_pulse = 0, m_irq = 0, m_hold = 0, m_mute = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mask <= '0; m_sticky <= '0; m_rd <= '0;
      m_pulse <= 0; m_irq <= 0; m_hold <= 0; m_mute <= 0;
    end else begin
      logic [6:0] taken;
      logic samp;
      taken = sf_stb ? (evt & m_mask) : 7'd0;
      samp = (taken[4:0] != 5'd0);
      if (rd_stb) begin
        m_rd <= {1'b0, m_sticky};
        m_sticky <= taken;
      end else begin
        m_sticky <= m_sticky | taken;
      end
      if (mask_wr) m_mask <= mask_wdata;
      m_pulse <= (taken != 7'd0);
      m_irq <= ((m_sticky & m_mask) != 7'd0);
      if (sf_stb) begin
        m_hold <= samp && (hold_mode == 2'b00);
        m_mute <= samp && (hold_mode == 2'b01);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R4 rd_data", rd_data, m_rd);
      chk("R6 rerr_pulse", {7'd0, rerr_pulse}, {7'd0, m_pulse});
      chk("R7 irq", {7'd0, irq}, {7'd0, m_irq});
      chk("R8 sub_hold", {7'd0, sub_hold}, {7'd0, m_hold});
      chk("R8 sub_mute", {7'd0, sub_mute}, {7'd0, m_mute});
    end
  end

  // one cycle of stimulus, returns at the next falling edge
  task automatic cyc(input logic [6:0] e, input logic sf, input logic rd);
    evt = e; sf_stb = sf; rd_stb = rd;
    @(negedge clk);
    evt = '0; sf_stb = 0; rd_stb = 0; mask_wr = 0;
  endtask

  task automatic wmask(input logic [6:0] m);
    mask_wr = 1; mask_wdata = m;
    cyc(7'd0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 outputs", {4'd0, rerr_pulse, irq, sub_hold, sub_mute}, 8'h00);

    // R2: reset mask blocks everything
    cyc(7'h7F, 1, 0);
    chk("R2 no pulse", {7'd0, rerr_pulse}, 8'h00);
    cyc(7'd0, 0, 1);
    chk("R2 nothing logged", rd_data, 8'h00);

    wmask(7'h7F);
    // R3/R11: parity is bit 0
    cyc(7'h01, 1, 0);
    chk("R6 pulse", {7'd0, rerr_pulse}, 8'h01);
    cyc(7'd0, 0, 0);
    chk("R6 pulse one cycle", {7'd0, rerr_pulse}, 8'h00);
    chk("R7 irq high", {7'd0, irq}, 8'h01);
    cyc(7'd0, 1, 0);
    cyc(7'd0, 0, 1);
    chk("R3 sticky parity", rd_data, 8'h01);
    cyc(7'd0, 0, 1);
    chk("R4 second read clear", rd_data, 8'h00);
    cyc(7'd0, 0, 0);
    chk("R7 irq low", {7'd0, irq}, 8'h00);

    // R11: validity is bit 3, Q CRC is bit 6
    cyc(7'h08, 1, 0);
    cyc(7'h40, 1, 0);
    cyc(7'd0, 0, 1);
    chk("R11 validity+qcrc", rd_data, 8'h48);

    // R5: event during read
    cyc(7'h04, 1, 0);
    cyc(7'h02, 1, 1);
    chk("R5 old value", rd_data, 8'h04);
    cyc(7'd0, 0, 1);
    chk("R5 new bit kept", rd_data, 8'h02);

    // R9: CRC does not touch sample
    hold_mode = 2'b00;
    cyc(7'h60, 1, 0);
    chk("R9 crc no hold", {6'd0, sub_hold, sub_mute}, 8'h00);
    cyc(7'h10, 1, 0);
    chk("R8 hold", {6'd0, sub_hold, sub_mute}, 8'h02);
    // R10: stable without boundary
    cyc(7'd0, 0, 0);
    cyc(7'd0, 0, 1);
    chk("R10 hold kept", {6'd0, sub_hold, sub_mute}, 8'h02);
    cyc(7'd0, 1, 0);
    chk("R10 cleared on boundary", {6'd0, sub_hold, sub_mute}, 8'h00);
    hold_mode = 2'b01;
    cyc(7'h01, 1, 0);
    chk("R8 mute", {6'd0, sub_hold, sub_mute}, 8'h01);
    hold_mode = 2'b10;
    cyc(7'h01, 1, 0);
    chk("R8 pass", {6'd0, sub_hold, sub_mute}, 8'h00);

    // R2: masking a single bit
    wmask(7'h7E);
    cyc(7'd0, 0, 1);
    cyc(7'h01, 1, 0);
    cyc(7'd0, 0, 1);
    chk("R2 masked parity", rd_data, 8'h00);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      hold_mode = 2'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        mask_wr = 1; mask_wdata = 7'($urandom);
      end
      cyc(7'($urandom) & 7'($urandom), ($urandom_range(0, 2) == 0),
          ($urandom_range(0, 4) == 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule